// File: doc/BRIEF.md
# Low-Power Domain Clock and Reset Control Registers

This block is the software-visible control point for a low-power peripheral domain. A processor reaches it over a 32-bit APB-style register bus. It collects hardware event flags into an interrupt status register and gates them with a mask. Software never writes the mask directly: one alias address unmasks sources and another masks them. The single interrupt line is high while any unmasked status bit is set.

The block also drives the reset lines of the domain's peripherals: processor cores, DMA channels, UARTs, Ethernet MACs and one USB controller. Each line is a stored register bit, and a reset line moves only when a write changes the stored field. A single DMA bit holds every DMA channel in reset or releases them together. A read-only PLL status word reports lock and stability. A bank of reference-clock control words holds whatever software writes, for readback. No clock generation takes place inside the block.

All accesses are full 32-bit words on byte addresses. Bus transfers complete in one cycle and `pready` is always high. A write takes effect at the clock edge where `psel`, `penable` and `pwrite` are all high. A read returns combinational data while `psel` is high.

Top module: `lpd_clkrst_ctl`

## Requirements
- R1: `irq` is high exactly when some status bit (offset 0x000) is 1 while the mask bit at the same position (offset 0x004) is 0. It follows register state with no added latency.
- R2: A write to offset 0x008 clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Offset 0x008 reads as zero.
- R3: A write to offset 0x00C sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Offset 0x00C reads as zero.
- R4: Writing a 1 to a status bit at offset 0x000 clears that bit, and writing a 0 leaves it unchanged. A 1 on `irq_evt[k]` sets status bit k, and this wins over a clear of the same bit in the same cycle.
- R5: After reset, status reads 0, the mask reads all ones, `irq` is low, and PLL status reads 0x3. Every reset output is 1 (held in reset), and every clock control word reads 0.
- R6: Offset 0x040 holds one field per core: bit i drives `rst_core[i]` and is independent of the other cores' bits.
- R7: A reset output changes only when a write to its register carries a value different from the stored one. Rewriting the same value leaves the output unchanged.
- R8: Bit 0 of offset 0x044 drives every bit of `rst_dma` together.
- R9: Each reset register has its own one-bit field in bit 0, and that bit drives its output. USB is at 0x048, UART u is at 0x060+4u and MAC m is at 0x070+4m.
- R10: PLL status at offset 0x010 (bit 0 lock, bit 1 stable) is read-only, and writes to it have no effect.
- R11: The clock control words at 0x080+4k (k below NUM_CLK) store all 32 written bits and read them back.
- R12: An access whose address has nonzero bits [1:0], or an address that is not mapped, reads as zero and changes no state.
- R13: Offset 0x004 returns the mask, and direct writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer done, always high |
| irq_evt | input | IRQ_W | Event pulses that set status bits |
| irq | output | 1 | Interrupt request |
| rst_core | output | NUM_CORE | Core reset lines |
| rst_dma | output | NUM_DMA | DMA channel reset lines |
| rst_uart | output | NUM_UART | UART reset lines |
| rst_mac | output | NUM_MAC | Ethernet MAC reset lines |
| rst_usb | output | 1 | USB controller reset line |

## Verification
The hardest case to reach is the cycle where an event pulse and a write-one-to-clear hit the same status bit. Two other cases are close behind: rewriting a reset field with its current value, and stray writes to unmapped or misaligned addresses. None of these shows up on `irq` or the reset lines unless the stimulus arranges it. Directed sequences drive an event and a clear on the same bit in one bus cycle, unmask the bit and then read status back. They rewrite core and UART fields with unchanged values and take snapshots of the outputs. A randomized phase then mixes events with writes to every alias, to misaligned addresses and to unmapped addresses, and compares against a behavioural model on every clock.

// File: rtl/lpdc_pkg.sv
// Package: shared address map and constants for the low-power domain
// clock/reset control block. Assumes 12-bit byte addresses and word access.
package lpdc_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_STATUS    = 12'h000;
    localparam logic [ADDR_W-1:0] A_MASK      = 12'h004;
    localparam logic [ADDR_W-1:0] A_UNMASK    = 12'h008;
    localparam logic [ADDR_W-1:0] A_SETMASK   = 12'h00C;
    localparam logic [ADDR_W-1:0] A_PLL       = 12'h010;
    localparam logic [ADDR_W-1:0] A_CORE      = 12'h040;
    localparam logic [ADDR_W-1:0] A_DMA       = 12'h044;
    localparam logic [ADDR_W-1:0] A_USB       = 12'h048;
    localparam logic [ADDR_W-1:0] A_UART_BASE = 12'h060;
    localparam logic [ADDR_W-1:0] A_MAC_BASE  = 12'h070;
    localparam logic [ADDR_W-1:0] A_CLK_BASE  = 12'h080;

    // PLL status: bit 0 lock, bit 1 stable
    localparam logic [1:0] PLL_RESET_VAL = 2'b11;

    // Decoded single-register write strobes
    typedef struct packed {
        logic status;
        logic unmask;
        logic setmask;
        logic core;
        logic dma;
        logic usb;
    } lpdc_wsel_t;
endpackage

// File: rtl/lpdc_irq_ctl.sv
// Module: interrupt status and mask. Status is write-one-to-clear with event
// inputs taking priority; the mask is changed only through set/clear strobes.
// Assumes the set and clear strobes are never active in the same cycle.
module lpdc_irq_ctl #(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] evt,
    input  logic             wr_status,
    input  logic             wr_unmask,
    input  logic             wr_setmask,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] status,
    output logic [IRQ_W-1:0] mask,
    output logic             irq
);
    logic [IRQ_W-1:0] clr_bits;

    // Purpose: select the bits a status write clears
    always_comb clr_bits = wr_status ? wdata : '0;

    // Purpose: status register, events win over clears
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_bits) | evt;
    end

    // Purpose: mask register, reset fully masked, edited via aliases
    always_ff @(posedge clk) begin
        if (!rst_n)          mask <= '1;
        else if (wr_unmask)  mask <= mask & ~wdata;
        else if (wr_setmask) mask <= mask | wdata;
    end

    // Purpose: interrupt request from unmasked pending bits
    always_comb irq = |(status & ~mask);
endmodule

// File: rtl/lpdc_rst_field.sv
// Module: one reset control field. Reset value holds the target in reset.
// The stored value (and so the output) is loaded only on a write whose data
// differs from the current contents.
module lpdc_rst_field #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic change;

    // Purpose: detect a write that alters the field
    always_comb change = wr && (wdata != q);

    // Purpose: hold the field, update only on change
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '1;
        else if (change) q <= wdata;
    end
endmodule

// File: rtl/lpdc_clk_bank.sv
// Module: bank of reference-clock control words, stored for readback only.
// Assumes the caller qualifies wr_en and rd_idx with an in-range decode.
module lpdc_clk_bank #(
    parameter int NUM_CLK = 16,
    parameter int W       = 32,
    localparam int IW     = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] words [NUM_CLK];

    for (genvar k = 0; k < NUM_CLK; k++) begin : g_word
        // Purpose: one stored control word
        always_ff @(posedge clk) begin
            if (!rst_n)                          words[k] <= '0;
            else if (wr_en && idx == IW'(k))     words[k] <= wdata;
        end
    end

    // Purpose: select the addressed word for reads
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CLK; k++) begin
            if (idx == IW'(k)) rdata = words[k];
        end
    end
endmodule

// File: rtl/lpd_clkrst_ctl.sv
// Module: top of the low-power domain clock/reset control registers.
// Decodes a single-cycle APB-style bus, routes writes to the interrupt,
// reset and clock-word submodules and builds read data. Assumes word
// accesses only; misaligned or unmapped addresses read zero and write nothing.
// Limits: NUM_UART, NUM_MAC <= 4; NUM_CLK <= 32; IRQ_W, NUM_CORE <= 32.
module lpd_clkrst_ctl
    import lpdc_pkg::*;
#(
    parameter int IRQ_W    = 8,
    parameter int NUM_CORE = 2,
    parameter int NUM_DMA  = 8,
    parameter int NUM_UART = 2,
    parameter int NUM_MAC  = 2,
    parameter int NUM_CLK  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    output logic                pready,
    input  logic [IRQ_W-1:0]    irq_evt,
    output logic                irq,
    output logic [NUM_CORE-1:0] rst_core,
    output logic [NUM_DMA-1:0]  rst_dma,
    output logic [NUM_UART-1:0] rst_uart,
    output logic [NUM_MAC-1:0]  rst_mac,
    output logic                rst_usb
);
    localparam int CIW = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1;
    localparam logic [ADDR_W-1:0] CLK_END = A_CLK_BASE + ADDR_W'(4 * NUM_CLK);

    logic             aligned;
    logic             wr_ok;
    lpdc_wsel_t       wsel;
    logic             clk_hit;
    logic [CIW-1:0]   clk_idx;
    logic [31:0]      clk_rdata;
    logic [IRQ_W-1:0] status_q;
    logic [IRQ_W-1:0] mask_q;
    logic             dma_q;

    // Purpose: qualify bus accesses and decode the fixed registers
    always_comb begin
        aligned      = (paddr[1:0] == 2'b00);
        wr_ok        = psel && penable && pwrite && aligned;
        wsel.status  = wr_ok && (paddr == A_STATUS);
        wsel.unmask  = wr_ok && (paddr == A_UNMASK);
        wsel.setmask = wr_ok && (paddr == A_SETMASK);
        wsel.core    = wr_ok && (paddr == A_CORE);
        wsel.dma     = wr_ok && (paddr == A_DMA);
        wsel.usb     = wr_ok && (paddr == A_USB);
        clk_hit      = (paddr >= A_CLK_BASE) && (paddr < CLK_END);
        clk_idx      = CIW'((paddr - A_CLK_BASE) >> 2);
    end

    assign pready = 1'b1;

    lpdc_irq_ctl #(.IRQ_W(IRQ_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (irq_evt),
        .wr_status  (wsel.status),
        .wr_unmask  (wsel.unmask),
        .wr_setmask (wsel.setmask),
        .wdata      (pwdata[IRQ_W-1:0]),
        .status     (status_q),
        .mask       (mask_q),
        .irq        (irq)
    );

    lpdc_rst_field #(.W(NUM_CORE)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wsel.core),
        .wdata (pwdata[NUM_CORE-1:0]),
        .q     (rst_core)
    );

    lpdc_rst_field #(.W(1)) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wsel.dma),
        .wdata (pwdata[0]),
        .q     (dma_q)
    );

    // One stored bit fans out to every DMA channel
    assign rst_dma = {NUM_DMA{dma_q}};

    lpdc_rst_field #(.W(1)) u_usb (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wsel.usb),
        .wdata (pwdata[0]),
        .q     (rst_usb)
    );

    for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
        localparam logic [ADDR_W-1:0] A_U = A_UART_BASE + ADDR_W'(4 * u);
        lpdc_rst_field #(.W(1)) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_ok && (paddr == A_U)),
            .wdata (pwdata[0]),
            .q     (rst_uart[u])
        );
    end

    for (genvar m = 0; m < NUM_MAC; m++) begin : g_mac
        localparam logic [ADDR_W-1:0] A_M = A_MAC_BASE + ADDR_W'(4 * m);
        lpdc_rst_field #(.W(1)) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_ok && (paddr == A_M)),
            .wdata (pwdata[0]),
            .q     (rst_mac[m])
        );
    end

    lpdc_clk_bank #(.NUM_CLK(NUM_CLK), .W(32)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ok && clk_hit),
        .idx   (clk_idx),
        .wdata (pwdata),
        .rdata (clk_rdata)
    );

    // Purpose: read data multiplexer, zero for anything unmapped
    always_comb begin
        prdata = '0;
        if (psel && aligned) begin
            if (paddr == A_STATUS) prdata[IRQ_W-1:0]    = status_q;
            if (paddr == A_MASK)   prdata[IRQ_W-1:0]    = mask_q;
            if (paddr == A_PLL)    prdata[1:0]          = PLL_RESET_VAL;
            if (paddr == A_CORE)   prdata[NUM_CORE-1:0] = rst_core;
            if (paddr == A_DMA)    prdata[0]            = dma_q;
            if (paddr == A_USB)    prdata[0]            = rst_usb;
            for (int u = 0; u < NUM_UART; u++) begin
                if (paddr == A_UART_BASE + ADDR_W'(4 * u)) prdata[0] = rst_uart[u];
            end
            for (int m = 0; m < NUM_MAC; m++) begin
                if (paddr == A_MAC_BASE + ADDR_W'(4 * m)) prdata[0] = rst_mac[m];
            end
            if (clk_hit) prdata = clk_rdata;
        end
    end
endmodule

// File: rtl/lpdc_chk.sv
// Module: assertion checker for lpd_clkrst_ctl, attached with bind.
// Decodes bus writes on its own and relates them to mask, status and
// reset outputs one cycle later.
module lpdc_chk
    import lpdc_pkg::*;
#(
    parameter int IRQ_W    = 8,
    parameter int NUM_CORE = 2,
    parameter int NUM_DMA  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic [ADDR_W-1:0]   paddr,
    input logic [IRQ_W-1:0]    wdata,
    input logic [IRQ_W-1:0]    irq_evt,
    input logic                irq,
    input logic [IRQ_W-1:0]    status,
    input logic [IRQ_W-1:0]    mask,
    input logic [NUM_CORE-1:0] rst_core,
    input logic [NUM_DMA-1:0]  rst_dma
);
    logic wr_any, wr_un, wr_set, wr_core, wr_dma;

    // Purpose: independent write decode for the properties
    always_comb begin
        wr_any  = psel && penable && pwrite;
        wr_un   = wr_any && (paddr == A_UNMASK);
        wr_set  = wr_any && (paddr == A_SETMASK);
        wr_core = wr_any && (paddr == A_CORE);
        wr_dma  = wr_any && (paddr == A_DMA);
    end

    p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1 || status == '0) |-> !irq);

    p_unmask_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_un |=> (mask & $past(wdata)) == '0);

    p_setmask_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (mask & $past(wdata)) == $past(wdata));

    p_mask_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_un || wr_set) |=> $stable(mask));

    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt != '0) |=> (status & $past(irq_evt)) == $past(irq_evt));

    p_core_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_core |=> $stable(rst_core));

    p_dma_fanout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dma |=> rst_dma == {NUM_DMA{$past(wdata[0])}});
endmodule

bind lpd_clkrst_ctl lpdc_chk #(
    .IRQ_W    (IRQ_W),
    .NUM_CORE (NUM_CORE),
    .NUM_DMA  (NUM_DMA)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .wdata    (pwdata[IRQ_W-1:0]),
    .irq_evt  (irq_evt),
    .irq      (irq),
    .status   (status_q),
    .mask     (mask_q),
    .rst_core (rst_core),
    .rst_dma  (rst_dma)
);

// File: tb/lpd_clkrst_ctl_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus
// directed and randomized register traffic.
module lpd_clkrst_ctl_tb_top;
    localparam int NCLK = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [7:0]  irq_evt = '0;
    logic        irq;
    logic [1:0]  rst_core;
    logic [7:0]  rst_dma;
    logic [1:0]  rst_uart;
    logic [1:0]  rst_mac;
    logic        rst_usb;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit armed = 0;
    bit rst_req = 1;

    // reference model state
    logic [7:0]  m_st, m_mask;
    logic [1:0]  m_core, m_uart, m_mac;
    logic        m_dma, m_usb;
    logic [31:0] m_clk [NCLK];

    always #10 clk = ~clk;

    lpd_clkrst_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .irq_evt(irq_evt), .irq(irq), .rst_core(rst_core),
        .rst_dma(rst_dma), .rst_uart(rst_uart), .rst_mac(rst_mac),
        .rst_usb(rst_usb)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mreset();
        m_st = '0; m_mask = '1; m_core = '1; m_dma = 1'b1; m_usb = 1'b1;
        m_uart = '1; m_mac = '1;
        for (int k = 0; k < NCLK; k++) m_clk[k] = '0;
    endtask

    function automatic logic [31:0] mread(input logic [11:0] a);
        if (a[1:0] != 2'b00) return '0;
        if (a == 12'h000) return {24'b0, m_st};
        if (a == 12'h004) return {24'b0, m_mask};
        if (a == 12'h010) return 32'h3;
        if (a == 12'h040) return {30'b0, m_core};
        if (a == 12'h044) return {31'b0, m_dma};
        if (a == 12'h048) return {31'b0, m_usb};
        if (a == 12'h060) return {31'b0, m_uart[0]};
        if (a == 12'h064) return {31'b0, m_uart[1]};
        if (a == 12'h070) return {31'b0, m_mac[0]};
        if (a == 12'h074) return {31'b0, m_mac[1]};
        if (a >= 12'h080 && a < 12'h0C0) return m_clk[(a - 12'h080) >> 2];
        return '0;
    endfunction

    task automatic mapply(input logic sel, input logic wr, input logic [11:0] a,
                          input logic [31:0] d, input logic [7:0] ev);
        logic w;
        w = sel && wr && (a[1:0] == 2'b00);
        m_st = (m_st & ~((w && a == 12'h000) ? d[7:0] : 8'h00)) | ev;
        if (w) begin
            if (a == 12'h008) m_mask = m_mask & ~d[7:0];
            if (a == 12'h00C) m_mask = m_mask | d[7:0];
            if (a == 12'h040) m_core = d[1:0];
            if (a == 12'h044) m_dma = d[0];
            if (a == 12'h048) m_usb = d[0];
            if (a == 12'h060) m_uart[0] = d[0];
            if (a == 12'h064) m_uart[1] = d[0];
            if (a == 12'h070) m_mac[0] = d[0];
            if (a == 12'h074) m_mac[1] = d[0];
            if (a >= 12'h080 && a < 12'h0C0) m_clk[(a - 12'h080) >> 2] = d;
        end
    endtask

    function automatic string tag_of(input logic [11:0] a);
        if (a[1:0] != 2'b00) return "R12";
        if (a == 12'h000) return "R4";
        if (a == 12'h004) return "R13";
        if (a == 12'h008) return "R2";
        if (a == 12'h00C) return "R3";
        if (a == 12'h010) return "R10";
        if (a == 12'h040) return "R6";
        if (a == 12'h044) return "R8";
        if (a == 12'h048 || a == 12'h060 || a == 12'h064 || a == 12'h070 || a == 12'h074) return "R9";
        if (a >= 12'h080 && a < 12'h0C0) return "R11";
        return "R12";
    endfunction

    // Purpose: compare all outputs against the model (every clock)
    task automatic compare_outputs();
        if (!armed) return;
        check("R1 irq", {31'b0, irq}, {31'b0, |(m_st & ~m_mask)});
        check("R6 rst_core", {30'b0, rst_core}, {30'b0, m_core});
        check("R8 rst_dma", {24'b0, rst_dma}, {24'b0, {8{m_dma}}});
        check("R9 rst_uart", {30'b0, rst_uart}, {30'b0, m_uart});
        check("R9 rst_mac", {30'b0, rst_mac}, {30'b0, m_mac});
        check("R9 rst_usb", {31'b0, rst_usb}, {31'b0, m_usb});
    endtask

    // Purpose: one bus cycle; inputs change at negedge, model steps at posedge
    task automatic cyc(input logic sel, input logic wr, input logic [11:0] a,
                       input logic [31:0] d, input logic [7:0] ev, input string tag);
        logic rq;
        @(negedge clk);
        compare_outputs();
        rq = rst_req;
        rst_n = !rq; psel = sel; penable = sel; pwrite = wr;
        paddr = a; pwdata = d; irq_evt = ev;
        #1;
        if (armed && sel && !wr && !rq) check(tag, prdata, mread(a));
        @(posedge clk);
        if (rq) begin mreset(); armed = 1; end
        else mapply(sel, wr, a, d, ev);
    endtask

    task automatic idle();               cyc(0, 0, 12'h000, 0, 8'h00, ""); endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1, 1, a, d, 8'h00, ""); endtask
    task automatic rd(input logic [11:0] a); cyc(1, 0, a, 0, 8'h00, tag_of(a)); endtask
    task automatic rdt(input logic [11:0] a, input string t); cyc(1, 0, a, 0, 8'h00, t); endtask

    // Purpose: reset-state reads with fixed expected values
    task automatic reset_checks();
        @(negedge clk); #2;
        check("R5 irq low", {31'b0, irq}, 32'h0);
        check("R5 rst_core", {30'b0, rst_core}, 32'h3);
        check("R5 rst_dma", {24'b0, rst_dma}, 32'hFF);
        check("R5 uart/mac/usb", {27'b0, rst_uart, rst_mac, rst_usb}, 32'h1F);
        rdt(12'h000, "R5 status");
        rdt(12'h004, "R5 mask");
        rdt(12'h010, "R5 pll");
        rdt(12'h080, "R5 clk word");
        check("R5 mask value", mread(12'h004), 32'hFF);
        check("R5 pll value", mread(12'h010), 32'h3);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [1:0]  snap;
        logic        snapu;
        mreset();
        rst_req = 1; idle(); idle(); idle();
        rst_req = 0;
        reset_checks();

        // R1 R2: events while masked, then unmask one source
        cyc(0, 0, 12'h000, 0, 8'h05, "");
        idle();
        rd(12'h000);
        check("R1 masked events no irq", {31'b0, irq}, 32'h0);
        wr(12'h008, 32'h01);
        idle();
        #5 check("R1 R2 unmasked pending raises irq", {31'b0, irq}, 32'h1);
        rd(12'h004); rd(12'h008);
        // R3: mask again, then unmask bit 2
        wr(12'h00C, 32'h01); idle();
        #5 check("R3 mask drops irq", {31'b0, irq}, 32'h0);
        rd(12'h00C);
        wr(12'h008, 32'h04); rd(12'h004);
        // R4: clear bit 2, then clear with simultaneous event
        wr(12'h000, 32'h04); rd(12'h000);
        wr(12'h008, 32'h02);
        cyc(1, 1, 12'h000, 32'h02, 8'h02, "");
        rd(12'h000);
        check("R4 event beats clear", mread(12'h000) & 32'h2, 32'h2);
        wr(12'h000, 32'hFF); rd(12'h000);
        // R13: direct mask write ignored
        wr(12'h004, 32'h00); rd(12'h004);
        // R10: PLL status read-only
        wr(12'h010, 32'h0); rd(12'h010);
        // R6 R7: per-core fields, same-value rewrite
        wr(12'h040, 32'h1); idle(); #5 snap = rst_core;
        check("R6 core0 held core1 released", {30'b0, snap}, 32'h1);
        wr(12'h040, 32'h1); idle();
        #5 check("R7 same value keeps core resets", {30'b0, rst_core}, {30'b0, snap});
        wr(12'h040, 32'h2); rd(12'h040);
        // R8: DMA fan-out
        wr(12'h044, 32'h0); rd(12'h044);
        wr(12'h044, 32'h1); rd(12'h044);
        // R9 R7: single-field registers
        wr(12'h060, 32'h0); wr(12'h074, 32'h0); wr(12'h048, 32'h0);
        idle(); #5 snapu = rst_uart[0];
        wr(12'h060, 32'hFFFFFFFE); idle();
        #5 check("R7 uart0 unchanged on same bit0", {31'b0, rst_uart[0]}, {31'b0, snapu});
        rd(12'h060); rd(12'h064); rd(12'h070); rd(12'h074); rd(12'h048);
        // R11: clock words
        for (int k = 0; k < NCLK; k++) wr(12'h080 + 12'(4 * k), 32'hA5C3_0000 ^ (k * 32'h0101_1111));
        for (int k = 0; k < NCLK; k++) rd(12'h080 + 12'(4 * k));
        // R12: misaligned and unmapped
        wr(12'h041, 32'h0); wr(12'h0FC, 32'hFFFF_FFFF); wr(12'h082, 32'h0);
        rd(12'h041); rd(12'h0FC); rd(12'h082); rd(12'h040); rd(12'h080);

        // randomized mix
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [7:0]  ev;
            int          pick;
            pick = $urandom % 16;
            case (pick)
                0: a = 12'h000;  1: a = 12'h004;  2: a = 12'h008;  3: a = 12'h00C;
                4: a = 12'h010;  5: a = 12'h040;  6: a = 12'h044;  7: a = 12'h048;
                8: a = 12'h060;  9: a = 12'h064; 10: a = 12'h070; 11: a = 12'h074;
                12: a = 12'h080 + 12'(4 * ($urandom % NCLK));
                13: a = 12'h0FC; 14: a = 12'h041 + 12'($urandom % 3);
                default: a = 12'h008;
            endcase
            ev = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            cyc(1, ($urandom % 2) == 1, a, $urandom, ev, tag_of(a));
        end

        // mid-run reset
        rst_req = 1; idle(); idle();
        rst_req = 0;
        reset_checks();
        idle(); idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule